// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of an integrating dual-slope converter. An external integrator and zero-crossing comparator do the analog work. The block tells the analog switch what to connect and counts clocks. A start command from idle begins a conversion. The integrator input goes to the unknown voltage for a fixed number of clocks. It then goes to the negative reference while a counter measures how long the integrator takes to return through zero. That count is held as the result.

One counter does three jobs. It times the fixed integrate window. It measures the variable de-integrate window. It also times a discharge phase, during which the capacitor is tied to ground so that the next conversion starts from zero charge. If the de-integrate count would pass the counter's maximum, the block sets an overflow flag and ends the conversion. The comparator is asynchronous to the block clock, so it passes through a register synchronizer first. A one-cycle completion pulse marks the end of each conversion.

Top module: `dslope_seq`

## Requirements
- R1: While reset is held, and in the first cycle after reset, the switch select is 00, and busy, done, overflow and result are all zero.
- R2: The switch select code means 00 = ground, 01 = unknown input, 10 = negative reference; 11 never appears. A start seen while idle gives busy = 1, select = 01 and overflow = 0 in the next cycle.
- R3: The select holds 01 for exactly INT_COUNT clock cycles, then changes straight to 10.
- R4: The comparator input (1 = integrator still on the charged side of zero) passes through SYNC_STAGES register stages. The de-integrate count starts at 0 and rises by one on each de-integrate clock whose synchronized value is 1. On the first clock whose synchronized value is 0, the count is stored as the result.
- R5: If the synchronized comparator is already 0 at the first de-integrate clock, the result is 0 and overflow stays 0.
- R6: If the de-integrate count is all ones and the synchronized comparator is still 1, the block sets overflow to 1, stores an all-ones result and ends the de-integrate phase.
- R7: If the crossing is seen on the same clock that the count is all ones, the crossing wins: the result is all ones and overflow stays 0.
- R8: After de-integrate ends, select is 00 with busy high for exactly DIS_CYCLES cycles. Then busy falls and done is high for exactly one cycle, in the same cycle that busy falls.
- R9: A start while busy has no effect: the select sequence, result and overflow of the running conversion are unchanged.
- R10: While idle, the result and overflow keep their values until the next start is accepted. That start clears overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command, acted on only while idle |
| cmp_i | input | 1 | Asynchronous comparator: 1 while the integrator is on the charged side of zero |
| sel_o | output | 2 | Analog switch select: 00 ground, 01 input, 10 negative reference |
| busy_o | output | 1 | High from an accepted start until the end of discharge |
| done_o | output | 1 | One-cycle pulse when a conversion finishes |
| ovf_o | output | 1 | Overflow flag of the last conversion |
| result_o | output | CNT_W | Held de-integrate count of the last conversion |

## Verification
The critical coincidence is the comparator crossing and the counter reaching all ones on the same de-integrate clock. The block must treat this as a valid full-scale reading, not an overflow. The bench models the integrator as an accumulator that adds the input code while the select is 01, subtracts a reference step while it is 10, and clears while it is 00. It picks the input value whose crossing, after the synchronizer delay, lands on exactly that clock. It then expects an all-ones result with overflow low, and checks the neighbouring input value, which must overflow. A second overlap, a start pulse arriving while a conversion runs, is injected at random points. The bench judges it by an unchanged integrate length and a correct result.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

  typedef enum logic [1:0] {
    SEL_GND  = 2'b00,
    SEL_VIN  = 2'b01,
    SEL_VREF = 2'b10
  } sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INTEG,
    ST_DEINT,
    ST_DISCH
  } state_e;

  // Count value on which a window of n clocks has its last tick.
  function automatic int unsigned last_tick(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  // Analog switch select implied by a sequencer state.
  function automatic sel_e sel_of(input state_e st);
    case (st)
      ST_INTEG: return SEL_VIN;
      ST_DEINT: return SEL_VREF;
      default:  return SEL_GND;
    endcase
  endfunction

endpackage

// File: rtl/dslope_sync.sv
module dslope_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/dslope_cnt.sv
module dslope_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o,
  output logic         full_o
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (inc_i) q_o <= q_o + 1'b1;
  end

  assign full_o = (q_o == ALL_ONES);

endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
  import dslope_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int INT_COUNT  = 1000,
  parameter int DIS_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_s_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_full_i,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output state_e           state_o,
  output logic [CNT_W-1:0] result_o,
  output logic             ovf_o,
  output logic             done_o,
  output logic             cross_evt_o,
  output logic             full_evt_o,
  output logic             tc_evt_o
);

  localparam logic [CNT_W-1:0] INT_LAST = CNT_W'(last_tick(INT_COUNT));
  localparam logic [CNT_W-1:0] DIS_LAST = CNT_W'(last_tick(DIS_CYCLES));

  state_e           state_q, state_d;
  logic [CNT_W-1:0] result_d;
  logic             ovf_d;
  logic             done_d;
  logic             dis_evt;

  // Named events for the checker and the next-state logic.
  assign tc_evt_o    = (state_q == ST_INTEG) && (cnt_i == INT_LAST);
  assign cross_evt_o = (state_q == ST_DEINT) && !cmp_s_i;
  assign full_evt_o  = (state_q == ST_DEINT) && cnt_full_i;
  assign dis_evt     = (state_q == ST_DISCH) && (cnt_i == DIS_LAST);

  always_comb begin
    state_d   = state_q;
    result_d  = result_o;
    ovf_d     = ovf_o;
    done_d    = 1'b0;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_INTEG;
          ovf_d     = 1'b0;
          cnt_clr_o = 1'b1;
        end
      end
      ST_INTEG: begin
        if (tc_evt_o) begin
          state_d   = ST_DEINT;
          cnt_clr_o = 1'b1;
        end else begin
          cnt_inc_o = 1'b1;
        end
      end
      ST_DEINT: begin
        if (cross_evt_o) begin
          // crossing has priority over a full counter
          state_d   = ST_DISCH;
          result_d  = cnt_i;
          cnt_clr_o = 1'b1;
        end else if (full_evt_o) begin
          state_d   = ST_DISCH;
          result_d  = cnt_i;
          ovf_d     = 1'b1;
          cnt_clr_o = 1'b1;
        end else begin
          cnt_inc_o = 1'b1;
        end
      end
      ST_DISCH: begin
        if (dis_evt) begin
          state_d   = ST_IDLE;
          done_d    = 1'b1;
          cnt_clr_o = 1'b1;
        end else begin
          cnt_inc_o = 1'b1;
        end
      end
      default: begin
        state_d   = ST_IDLE;
        cnt_clr_o = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      result_o <= '0;
      ovf_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      state_q  <= state_d;
      result_o <= result_d;
      ovf_o    <= ovf_d;
      done_o   <= done_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int INT_COUNT   = 1000,
  parameter int DIS_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [1:0]       sel_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovf_o,
  output logic [CNT_W-1:0] result_o
);

  logic             cmp_s;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_full;
  logic             cnt_clr;
  logic             cnt_inc;
  state_e           state;
  logic             cross_evt;
  logic             full_evt;
  logic             tc_evt;

  dslope_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  dslope_cnt #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .q_o    (cnt_q),
    .full_o (cnt_full)
  );

  dslope_ctrl #(
    .CNT_W      (CNT_W),
    .INT_COUNT  (INT_COUNT),
    .DIS_CYCLES (DIS_CYCLES)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cmp_s_i     (cmp_s),
    .cnt_i       (cnt_q),
    .cnt_full_i  (cnt_full),
    .cnt_clr_o   (cnt_clr),
    .cnt_inc_o   (cnt_inc),
    .state_o     (state),
    .result_o    (result_o),
    .ovf_o       (ovf_o),
    .done_o      (done_o),
    .cross_evt_o (cross_evt),
    .full_evt_o  (full_evt),
    .tc_evt_o    (tc_evt)
  );

  assign sel_o  = sel_of(state);
  assign busy_o = (state != ST_IDLE);

endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
  parameter int CNT_W     = 16,
  parameter int INT_COUNT = 1000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [1:0]       sel_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             ovf_o,
  input logic [CNT_W-1:0] result_o,
  input logic             cross_evt,
  input logic             full_evt,
  input logic             tc_evt
);

  // Length of the current run of input-select cycles.
  logic [31:0] vin_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               vin_run <= '0;
    else if (sel_o == 2'b01)  vin_run <= vin_run + 1;
    else                      vin_run <= '0;
  end

  p_sel_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o != 2'b11);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && sel_o == 2'b01 && !ovf_o));

  p_int_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o == 2'b10 && $past(sel_o) == 2'b01) |-> (vin_run == INT_COUNT));

  p_tc_switch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |=> (sel_o == 2'b10));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cross_evt && full_evt) |=> (!ovf_o && result_o == {CNT_W{1'b1}}));

  p_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_evt && !cross_evt) |=> (ovf_o && sel_o == 2'b00 && busy_o));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && sel_o == 2'b00));

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && sel_o != 2'b01) |=> (sel_o != 2'b01));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(result_o) && $stable(ovf_o)));

endmodule

bind dslope_seq dslope_seq_chk #(
  .CNT_W     (CNT_W),
  .INT_COUNT (INT_COUNT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .sel_o     (sel_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .ovf_o     (ovf_o),
  .result_o  (result_o),
  .cross_evt (cross_evt),
  .full_evt  (full_evt),
  .tc_evt    (tc_evt)
);

// File: tb/dslope_seq_bench.sv
`timescale 1ns/1ps
module dslope_seq_bench;

  localparam int CW   = 8;
  localparam int NINT = 40;
  localparam int NDIS = 4;
  localparam int VREF = 37;
  localparam int FULL = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          cmp_i;
  logic [1:0]    sel_o;
  logic          busy_o, done_o, ovf_o;
  logic [CW-1:0] result_o;

  int     vin = 0;
  longint acc = 0;
  int     checks = 0;
  int     fails = 0;
  bit     finished = 1'b0;

  always #2.5 clk = ~clk;

  dslope_seq #(
    .CNT_W       (CW),
    .INT_COUNT   (NINT),
    .DIS_CYCLES  (NDIS),
    .SYNC_STAGES (2)
  ) u_dslope_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cmp_i    (cmp_i),
    .sel_o    (sel_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .ovf_o    (ovf_o),
    .result_o (result_o)
  );

  // Behavioural integrator: charge with the input, discharge with the reference, zero on ground.
  always @(posedge clk) begin
    case (sel_o)
      2'b01:   acc <= acc + vin;
      2'b10:   acc <= acc - VREF;
      default: acc <= 0;
    endcase
  end
  assign cmp_i = (acc > 0);

  // Count expected from the requirements: reference steps k to pass zero,
  // plus two synchronizer stages before the stop is seen.
  function automatic int exp_count(input int v);
    int k;
    if (v == 0) return 0;
    k = (NINT * v + VREF - 1) / VREF;
    return k + 2;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic convert(input int v, input int poke);
    int  n_vin;
    int  n_dis;
    bit  got;
    int  e;
    bit  e_ovf;
    int  e_res;
    logic [CW-1:0] r_hold;
    logic          o_hold;
    string tag;
    vin = v;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(busy_o && sel_o == 2'b01, "R2 start", {busy_o, sel_o}, 5);
    chk(!ovf_o, "R10 ovf cleared by start", ovf_o, 0);
    n_vin = 1;
    n_dis = 0;
    got = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      start_i = (c == poke);
      if (sel_o == 2'b01) n_vin++;
      if (busy_o && sel_o == 2'b00) n_dis++;
      if (done_o) begin
        got = 1'b1;
        break;
      end
    end
    start_i = 1'b0;
    e = exp_count(v);
    e_ovf = (e > FULL);
    e_res = e_ovf ? FULL : e;
    if (v == 0)          tag = "R5 zero";
    else if (e_ovf)      tag = "R6 overflow";
    else if (e == FULL)  tag = "R7 crossing at full";
    else                 tag = "R4 count";
    chk(got, "R8 done seen", got, 1);
    chk(!busy_o, "R8 busy low with done", busy_o, 0);
    chk(n_vin == NINT, "R3 integrate length", n_vin, NINT);
    chk(n_dis == NDIS, "R8 discharge length", n_dis, NDIS);
    chk(result_o == e_res, tag, result_o, e_res);
    chk(ovf_o == e_ovf, tag, ovf_o, e_ovf);
    if (poke >= 0)
      chk(n_vin == NINT && result_o == e_res, "R9 start while busy", result_o, e_res);
    r_hold = result_o;
    o_hold = ovf_o;
    @(negedge clk);
    chk(!done_o, "R8 done one cycle", done_o, 0);
    repeat ($urandom_range(4, 0)) @(negedge clk);
    chk(result_o == r_hold && ovf_o == o_hold, "R10 idle hold", result_o, r_hold);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int v;
    int p;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(sel_o == 2'b00 && !busy_o && !done_o && !ovf_o && result_o == 0,
        "R1 reset state", {sel_o, busy_o, done_o, ovf_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel_o == 2'b00 && !busy_o && !done_o && result_o == 0,
        "R1 after reset", {sel_o, busy_o, done_o}, 0);

    convert(0, -1);     // R5
    convert(1, -1);     // R4 smallest nonzero
    convert(234, -1);   // R7: crossing and full on the same clock
    convert(235, -1);   // R6: one step beyond
    convert(260, 10);   // R6 with start while busy, R9
    convert(0, 5);      // R5 with start during integrate
    convert(100, NINT + 2); // R9 during de-integrate

    for (int i = 0; i < 50; i++) begin
      v = $urandom_range(260, 0);
      p = ($urandom_range(1, 0) == 1) ? $urandom_range(NINT + 3, 0) : -1;
      convert(v, p);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule